// File: doc/BRIEF.md
# Warm Reset Sequencer

This block runs the warm reset handshake on a chip whose reset pin is open-drain and shared with the board. Either side may start a warm reset. An outside agent can pull the pin low, or software can write one trigger word to one register address. Once started, the block floats the data bus and holds every memory control output inactive. It then drives the pin low for a fixed number of master-clock cycles and lets go.

After it lets go, the block counts a second fixed interval. At the end of that interval it samples the synchronized pin. If the outside agent still holds the pin low, the block keeps waiting until the pin reads high. It then turns the data bus back on. A short guard interval follows, and during it the memory controls stay inhibited. At the end of the guard, a one-cycle CPU-start pulse tells the processor to begin. The block then returns to idle.

The cold reset is synchronous and active low. It drops any sequence in progress and releases every output. Clock generation is handled elsewhere and keeps running through a warm reset.

Top module: `warm_rst_seq`

## Requirements
- R1: From idle, a warm reset starts only when a single-cycle write has `reg_wr_en`=1, `reg_wr_addr` equal to RESET_ADDR (default 0x10) and `reg_wr_data` equal to TRIG_VALUE (default 0x8000_0001). Any other address or data word leaves `rst_pin_oe` at 0.
- R2: From idle, a warm reset starts when the synchronized pin reads low while the block is not driving it.
- R3: During the drive phase, `rst_pin_oe`=1 for exactly HOLD_CYCLES (default 4096) consecutive cycles. Throughout that phase, `bus_oe`=0 and `memctl_inhibit`=1.
- R4: After the block releases the pin, `bus_oe` stays 0 for SETTLE_CYCLES (default 4096) cycles. If the pin is still held low at that point, `bus_oe` stays 0 until the synchronized pin reads high.
- R5: After `bus_oe` returns to 1, `memctl_inhibit` stays 1 for GUARD_CYCLES (default 16) cycles. `cpu_start` pulses exactly once, in the last of those cycles. The block is then idle, with `memctl_inhibit`=0 and `rst_pin_oe`=0.
- R6: A register trigger or a low pin that occurs while a sequence is in progress has no effect. The phase lengths stay unchanged and the pin is not driven again.
- R7: With `cold_rst_n`=0 at a clock edge, the outputs after that edge are `rst_pin_oe`=0, `bus_oe`=1, `memctl_inhibit`=0 and `cpu_start`=0. This holds even in the middle of a sequence.
- R8: `rst_pin_i` passes through a two-flop synchronizer. If the pin goes low just after an edge while idle, `rst_pin_oe` becomes 1 after the third following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| cold_rst_n | input | 1 | Cold reset, synchronous, active low |
| rst_pin_i | input | 1 | Sampled level of the shared reset pin |
| rst_pin_oe | output | 1 | Pulls the reset pin low when 1 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wr_data | input | DATA_W | Register write data |
| bus_oe | output | 1 | Data bus output enable; 0 floats the bus |
| memctl_inhibit | output | 1 | Holds memory control outputs, including the first chip-select, inactive |
| cpu_start | output | 1 | One-cycle pulse that releases the processor |

## Verification
The assertions assume two things about the pin. First, `rst_pin_i` reads low only while the block or the outside agent is pulling it. Second, an outside pulse lasts long enough to pass the synchronizer. The bench models the pin as open-drain: the pin reads low whenever the block's enable or the modeled agent's drive is active. Its agent drops the pin only while the block is idle, or keeps holding a drive it started earlier. Register writes are driven as single-cycle strobes between clock edges.

// File: rtl/wrs_pkg.sv
// Package: shared state encoding for the warm reset sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package wrs_pkg;

    typedef enum logic [1:0] {
        WRS_IDLE   = 2'd0,
        WRS_HOLD   = 2'd1,
        WRS_SETTLE = 2'd2,
        WRS_GUARD  = 2'd3
    } wrs_state_e;

endpackage

// File: rtl/wrs_pin_sync.sv
// Module: multi-flop synchronizer for the shared reset pin.
// Assumes: the pin idles high, so every stage resets to 1 to avoid a false
// trigger on leaving cold reset.
module wrs_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain;

    // Shift the raw pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_async};
        end
    end

    assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/wrs_trig_decode.sv
// Module: decodes the software reset write (exact address and data match).
// Assumes: a write lasts one cycle; the match is combinational.
module wrs_trig_decode #(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 8'h10,
    parameter logic [DATA_W-1:0] TRIG_VALUE = 32'h8000_0001
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sw_hit
);

    // Flag a write of the trigger word to the reset register.
    always_comb begin
        sw_hit = wr_en && (wr_addr == RESET_ADDR) && (wr_data == TRIG_VALUE);
    end

endmodule

// File: rtl/wrs_phase_timer.sv
// Module: shared up-counter that times each phase of the sequence.
// Assumes: clr is pulsed on every phase change; limit is at least 1 and
// stays stable within a phase. The count saturates at limit-1.
module wrs_phase_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign done = (cnt >= (limit - CNT_W'(1)));

    // Count cycles in the current phase, stopping at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/warm_rst_seq.sv
// Module: warm reset sequencer. Starts on a software trigger or an outside pull
// of the open-drain reset pin. It drives the pin for a fixed hold, waits a
// settle interval and for the pin to read high, re-enables the bus, keeps a
// guard before memory controls are freed, then pulses cpu_start.
// Assumes: synchronous active-low cold reset; rst_pin_i is asynchronous.
module warm_rst_seq
    import wrs_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter int                DATA_W        = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR    = 8'h10,
    parameter logic [DATA_W-1:0] TRIG_VALUE    = 32'h8000_0001,
    parameter int                HOLD_CYCLES   = 4096,
    parameter int                SETTLE_CYCLES = 4096,
    parameter int                GUARD_CYCLES  = 16,
    parameter int                SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_pin_i,
    output logic              rst_pin_oe,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic              bus_oe,
    output logic              memctl_inhibit,
    output logic              cpu_start
);

    localparam int MAX_A   = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
    localparam int MAX_LIM = (MAX_A > GUARD_CYCLES) ? MAX_A : GUARD_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    wrs_state_e       state, state_nx;
    logic             pin_s;
    logic             sw_hit;
    logic             ph_done;
    logic             ph_clr;
    logic [CNT_W-1:0] ph_limit;

    wrs_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (cold_rst_n),
        .pin_async (rst_pin_i),
        .pin_sync  (pin_s)
    );

    wrs_trig_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .RESET_ADDR (RESET_ADDR),
        .TRIG_VALUE (TRIG_VALUE)
    ) u_decode (
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .sw_hit  (sw_hit)
    );

    wrs_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (cold_rst_n),
        .clr   (ph_clr),
        .limit (ph_limit),
        .done  (ph_done)
    );

    // Pick the cycle count of the phase in progress.
    always_comb begin
        case (state)
            WRS_HOLD:   ph_limit = CNT_W'(HOLD_CYCLES);
            WRS_SETTLE: ph_limit = CNT_W'(SETTLE_CYCLES);
            WRS_GUARD:  ph_limit = CNT_W'(GUARD_CYCLES);
            default:    ph_limit = CNT_W'(1);
        endcase
    end

    // Decide the next phase; triggers are only seen in idle.
    always_comb begin
        state_nx = state;
        case (state)
            WRS_IDLE:   if (sw_hit || !pin_s) state_nx = WRS_HOLD;
            WRS_HOLD:   if (ph_done) state_nx = WRS_SETTLE;
            WRS_SETTLE: if (ph_done && pin_s) state_nx = WRS_GUARD;
            WRS_GUARD:  if (ph_done) state_nx = WRS_IDLE;
            default:    state_nx = WRS_IDLE;
        endcase
    end

    assign ph_clr = (state_nx != state);

    // Hold the phase register; cold reset forces idle.
    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            state <= WRS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Decode the pin, bus and start outputs from the phase.
    always_comb begin
        rst_pin_oe     = (state == WRS_HOLD);
        bus_oe         = (state == WRS_IDLE) || (state == WRS_GUARD);
        memctl_inhibit = (state != WRS_IDLE);
        cpu_start      = (state == WRS_GUARD) && ph_done;
    end

    AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(rst_pin_oe) |-> ($past(sw_hit) || !$past(pin_s))); // R1
    AST_EXT_TRIGGER: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (state == WRS_IDLE && !pin_s) |=> rst_pin_oe); // R2
    AST_RELEASE_BUS_OFF: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $fell(rst_pin_oe) |-> (!bus_oe && memctl_inhibit)); // R3
    AST_BUS_NEEDS_PIN: assert property (@(posedge clk) disable iff (!cold_rst_n)
        ($rose(bus_oe) && memctl_inhibit) |-> pin_s); // R4
    AST_START_ONCE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        cpu_start |=> (!cpu_start && !memctl_inhibit && !rst_pin_oe)); // R5
    AST_SW_IGNORED: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (state == WRS_SETTLE && sw_hit) |=> !rst_pin_oe); // R6

endmodule

// File: tb/warm_rst_seq_tb.sv
module warm_rst_seq_tb;

    localparam int          ADDR_W = 8;
    localparam logic [7:0]  RA     = 8'h10;
    localparam logic [31:0] TV     = 32'h8000_0001;
    localparam int          HOLD   = 4096;
    localparam int          SETTLE = 4096;
    localparam int          GUARD  = 16;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        ext_low = 1'b0;
    logic        rst_pin_i;
    logic        rst_pin_oe;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        bus_oe, memctl_inhibit, cpu_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // {addr, data, expect_trigger}; the last entry starts a sequence (R1)
    localparam logic [40:0] VECS [5] = '{
        {8'h11, TV, 1'b0},
        {RA, 32'h8000_0000, 1'b0},
        {RA, 32'h0000_0001, 1'b0},
        {RA, 32'hFFFF_FFFF, 1'b0},
        {RA, TV, 1'b1}
    };

    assign rst_pin_i = !(rst_pin_oe || ext_low);

    warm_rst_seq u_dut (
        .clk            (clk),
        .cold_rst_n     (cold_rst_n),
        .rst_pin_i      (rst_pin_i),
        .rst_pin_oe     (rst_pin_oe),
        .reg_wr_en      (reg_wr_en),
        .reg_wr_addr    (reg_wr_addr),
        .reg_wr_data    (reg_wr_data),
        .bus_oe         (bus_oe),
        .memctl_inhibit (memctl_inhibit),
        .cpu_start      (cpu_start)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs from the first negedge sample with rst_pin_oe=1 to the idle return.
    task automatic run_seq(input int ext_extra, input bit poke);
        int hold = 1;
        int settle = 0;
        int guard = 0;
        int pulses = 0;
        int rel = 0;
        bit bus_bad = 0;
        bit last_start = 0;
        while (rst_pin_oe) begin
            @(negedge clk);
            reg_wr_en = poke && (hold == 100);
            reg_wr_addr = RA;
            reg_wr_data = TV;
            if (rst_pin_oe) begin
                hold++;
                if (bus_oe || !memctl_inhibit) bus_bad = 1;
            end
        end
        check(hold == HOLD, "R3 hold length", hold, HOLD);
        check(!bus_bad, "R3 bus off during hold", bus_bad, 0);
        while (!bus_oe) begin
            settle++;
            if (rel == ext_extra) ext_low = 1'b0;
            rel++;
            @(negedge clk);
            reg_wr_en = poke && (settle == 50);
            if (rst_pin_oe) bus_bad = 1;
        end
        reg_wr_en = 1'b0;
        check(!bus_bad, "R6 no re-drive", bus_bad, 0);
        if (ext_extra + 4 < SETTLE)
            check(settle == SETTLE, "R4 settle length", settle, SETTLE);
        else
            check(settle >= ext_extra && settle <= ext_extra + 4,
                  "R4 wait for pin release", settle, ext_extra);
        while (memctl_inhibit) begin
            guard++;
            last_start = cpu_start;
            if (cpu_start) pulses++;
            @(negedge clk);
        end
        check(guard == GUARD, "R5 guard length", guard, GUARD);
        check(pulses == 1 && last_start, "R5 single start pulse", pulses, 1);
        check(!rst_pin_oe && !cpu_start && bus_oe, "R5 back to idle",
              {rst_pin_oe, cpu_start, bus_oe}, 3'b001);
        repeat (20) @(negedge clk);
        check(!rst_pin_oe, "R2 own release not a trigger", rst_pin_oe, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rst_pin_oe && bus_oe && !memctl_inhibit && !cpu_start, "R7 reset state",
              {rst_pin_oe, bus_oe, memctl_inhibit, cpu_start}, 4'b0100);
        cold_rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: vector table of register writes
        for (int i = 0; i < 5; i++) begin
            reg_wr_en = 1'b1;
            reg_wr_addr = VECS[i][40:33];
            reg_wr_data = VECS[i][32:1];
            @(negedge clk);
            reg_wr_en = 1'b0;
            check(rst_pin_oe == VECS[i][0], "R1 write decode", rst_pin_oe, VECS[i][0]);
            if (VECS[i][0]) run_seq(0, 1'b0);
            else repeat (2) @(negedge clk);
        end

        // R8, R2: outside pull, held 300 cycles past own release (R4)
        ext_low = 1'b1;
        @(negedge clk);
        check(!rst_pin_oe, "R8 sync stage 1", rst_pin_oe, 0);
        @(negedge clk);
        check(!rst_pin_oe, "R8 sync stage 2", rst_pin_oe, 0);
        @(negedge clk);
        check(rst_pin_oe, "R2 outside trigger", rst_pin_oe, 1);
        run_seq(300, 1'b0);

        // R4: outside agent holds well beyond the settle interval
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        check(rst_pin_oe, "R2 outside trigger again", rst_pin_oe, 1);
        run_seq(5000, 1'b0);

        // R6: register triggers during hold and settle are ignored
        reg_wr_en = 1'b1; reg_wr_addr = RA; reg_wr_data = TV;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(rst_pin_oe, "R6 start for poke run", rst_pin_oe, 1);
        run_seq(0, 1'b1);

        // R7: cold reset in the middle of a hold
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (10) @(negedge clk);
        check(rst_pin_oe && !bus_oe, "R3 hold in progress", rst_pin_oe, 1);
        cold_rst_n = 1'b0;
        @(negedge clk);
        check(!rst_pin_oe && bus_oe && !memctl_inhibit && !cpu_start, "R7 cold reset mid hold",
              {rst_pin_oe, bus_oe, memctl_inhibit, cpu_start}, 4'b0100);
        repeat (2) @(negedge clk);
        cold_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!rst_pin_oe && !memctl_inhibit, "R7 stays idle after reset",
              {rst_pin_oe, memctl_inhibit}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule